// File: doc/BRIEF.md
# Gen2 Link-Recovery Stall Watchdog

This block watches a PCI Express link while it trains. On a fixed check interval it samples a link-up flag, the 6-bit LTSSM state and a receive-valid flag from the PHY. When the link is up it reports success and stops checking. A speed change to Gen2 can hang, with the LTSSM stuck in Recovery.RcvrLock (state code 0x0D) and the PHY reporting no valid receive data. When a check finds that condition, the block pulses a receiver override to free the receiver. It raises the receive-data-enable and receive-PLL-enable bits of the PHY override word for a fixed number of cycles and then lowers them. All other bits of that word keep their values.

The override is applied as a read-modify-write. The current PHY override word comes in on `ovr_rd_word`, and the block drives the merged word on `ovr_wr_word` together with a one-cycle `ovr_wr` strobe on each change. After a pulse ends, a full check interval passes before the next check, so two pulses never overlap. If the link does not come up within a bounded number of checks, the block reports failure. A saturating counter records how many stalls have been seen.

The register-access transport to the PHY lies outside the block. All interfaces are plain level or strobe signals and have no back-pressure.

Top module: `link_stall_watchdog`

## Requirements
- R1: After reset, `link_ok`, `link_fail`, `stall_pulse`, `ovr_wr` and `stall_count` are 0, and `ovr_wr_word` equals `ovr_rd_word` with bits 5 and 3 cleared.
- R2: A check happens every `GAP_CYCLES` cycles while the block is waiting. If `link_up` is 1 at a check, `link_ok` goes to 1 at the next edge and stays there until reset, and the block takes no further action.
- R3: A stall is present when a check finds `link_up`=0, `ltssm_state`=0x0D and `rx_valid`=0. In that case `stall_pulse` is 1 for the cycle after the check and the override is applied.
- R4: When `rx_valid`=1 at a check, no override is applied and `stall_count` does not change, whatever the LTSSM state.
- R5: When `ltssm_state` is not 0x0D at a check, no override is applied and `stall_count` does not change.
- R6: During an override, bits 5 (receive data enable) and 3 (receive PLL enable) of `ovr_wr_word` are 1 for exactly `HOLD_CYCLES` cycles and then return to 0. All other bits of `ovr_wr_word` always equal the same bits of `ovr_rd_word`.
- R7: `ovr_wr` is a one-cycle strobe in the first cycle the override bits are set and in the first cycle they are cleared, and it is 0 at all other times.
- R8: After an override ends, the next check happens `GAP_CYCLES` cycles later, so consecutive stall pulses are exactly `HOLD_CYCLES + GAP_CYCLES` cycles apart.
- R9: If `MAX_CHECKS` checks in a row find `link_up`=0, `link_fail` goes to 1 after the last of them and stays there until reset. The last check never starts an override. `link_ok` and `link_fail` are never 1 together.
- R10: `stall_count` increments on every stall pulse and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ltssm_state | input | 6 | Current LTSSM state code |
| link_up | input | 1 | Link-up debug flag |
| rx_valid | input | 1 | PHY receive-valid flag |
| ovr_rd_word | input | 16 | Current PHY override word (read side) |
| ovr_wr_word | output | 16 | Merged override word to write back |
| ovr_wr | output | 1 | One-cycle write strobe for `ovr_wr_word` |
| stall_pulse | output | 1 | One-cycle flag when an override is started |
| stall_count | output | CNT_W | Saturating count of stall events |
| link_ok | output | 1 | Link came up (sticky) |
| link_fail | output | 1 | Link never came up within the check budget (sticky) |

## Verification
The hardest situation to reach is a stall on the last permitted check, followed by saturation of the stall counter, all before the failure verdict. The bench holds the stall condition for a whole run with a small check budget and a narrow counter, so the counter saturates within a few pulses. In the same run the failure arrives after the final, override-free check. The bench times the gaps between pulses to confirm that the block re-arms only after the hold interval plus a full check interval. Random upper bits on the read word show that the read-modify-write never disturbs bits it does not own.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HOLD = 2'd1,
    PH_DONE = 2'd2
  } lrw_phase_e;

  function automatic logic [15:0] lrw_bit_mask(input int unsigned a, input int unsigned b);
    logic [15:0] m;
    m = '0;
    m[a] = 1'b1;
    m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lrw_interval.sv
module lrw_interval #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (done) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  assert_wraps_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == '0));
endmodule

// File: rtl/lrw_satcnt.sv
module lrw_satcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (inc && (value != CMAX)) begin
      value <= value + 1'b1;
    end
  end

  assert_no_decrease_R10: assert property (@(posedge clk) disable iff (!rst_n)
    value >= $past(value));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && value == CMAX) |=> (value == CMAX));
endmodule

// File: rtl/lrw_merge.sv
module lrw_merge #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned DATA_EN_BIT = 5,
  parameter int unsigned PLL_EN_BIT  = 3
) (
  input  logic [WORD_W-1:0] rd_word,
  input  logic              force_on,
  output logic [WORD_W-1:0] wr_word
);
  localparam logic [WORD_W-1:0] OWN_MASK =
    WORD_W'(lrw_pkg::lrw_bit_mask(DATA_EN_BIT, PLL_EN_BIT));

  always_comb begin
    wr_word = rd_word & ~OWN_MASK;
    if (force_on) begin
      wr_word = wr_word | OWN_MASK;
    end
  end

  always_comb begin
    assert_keeps_others_R6: assert ((wr_word | OWN_MASK) == (rd_word | OWN_MASK));
  end
endmodule

// File: rtl/lrw_ctrl.sv
module lrw_ctrl
  import lrw_pkg::*;
#(
  parameter int unsigned MAX_CHECKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_done,
  input  logic hold_done,
  input  logic link_up,
  input  logic stall_cond,
  output logic in_wait,
  output logic in_hold,
  output logic stall_fire,
  output logic ovr_on,
  output logic ovr_wr,
  output logic stall_pulse,
  output logic link_ok,
  output logic link_fail
);
  localparam int unsigned TRY_W = (MAX_CHECKS > 1) ? $clog2(MAX_CHECKS) : 1;
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_CHECKS - 1);

  lrw_phase_e     phase;
  logic [TRY_W-1:0] tries;
  logic           final_try;

  assign in_wait    = (phase == PH_WAIT);
  assign in_hold    = (phase == PH_HOLD);
  assign final_try  = (tries == LAST_TRY);
  assign stall_fire = in_wait && gap_done && !link_up && !final_try && stall_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_WAIT;
      tries       <= '0;
      ovr_on      <= 1'b0;
      ovr_wr      <= 1'b0;
      stall_pulse <= 1'b0;
      link_ok     <= 1'b0;
      link_fail   <= 1'b0;
    end else begin
      stall_pulse <= 1'b0;
      ovr_wr      <= 1'b0;
      unique case (phase)
        PH_WAIT: begin
          if (gap_done) begin
            if (link_up) begin
              link_ok <= 1'b1;
              phase   <= PH_DONE;
            end else if (final_try) begin
              link_fail <= 1'b1;
              phase     <= PH_DONE;
            end else begin
              tries <= tries + 1'b1;
              if (stall_cond) begin
                phase       <= PH_HOLD;
                ovr_on      <= 1'b1;
                ovr_wr      <= 1'b1;
                stall_pulse <= 1'b1;
              end
            end
          end
        end
        PH_HOLD: begin
          if (hold_done) begin
            ovr_on <= 1'b0;
            ovr_wr <= 1'b1;
            phase  <= PH_WAIT;
          end
        end
        default: begin
        end
      endcase
    end
  end

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pulse |=> !stall_pulse);
  assert_pulse_with_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pulse |-> ovr_on);
  assert_strobe_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_wr |-> (ovr_on != $past(ovr_on)));
  assert_change_has_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_on != $past(ovr_on)) |-> ovr_wr);
  assert_verdict_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_ok && link_fail));
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> link_fail);
  assert_ok_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |=> (link_ok && !ovr_on));
endmodule

// File: rtl/link_stall_watchdog.sv
module link_stall_watchdog #(
  parameter int unsigned GAP_CYCLES  = 1000,
  parameter int unsigned HOLD_CYCLES = 2500,
  parameter int unsigned MAX_CHECKS  = 200,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned STATE_W     = 6,
  parameter int unsigned WORD_W      = 16,
  parameter logic [5:0]  STALL_STATE = 6'h0D,
  parameter int unsigned DATA_EN_BIT = 5,
  parameter int unsigned PLL_EN_BIT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               link_up,
  input  logic               rx_valid,
  input  logic [WORD_W-1:0]  ovr_rd_word,
  output logic [WORD_W-1:0]  ovr_wr_word,
  output logic               ovr_wr,
  output logic               stall_pulse,
  output logic [CNT_W-1:0]   stall_count,
  output logic               link_ok,
  output logic               link_fail
);
  logic in_wait, in_hold, gap_done, hold_done, stall_cond, stall_fire, ovr_on;

  assign stall_cond = (ltssm_state == STATE_W'(STALL_STATE)) && !rx_valid;

  lrw_interval #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .done(gap_done)
  );

  lrw_interval #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(in_hold), .done(hold_done)
  );

  lrw_ctrl #(.MAX_CHECKS(MAX_CHECKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .gap_done(gap_done), .hold_done(hold_done),
    .link_up(link_up), .stall_cond(stall_cond),
    .in_wait(in_wait), .in_hold(in_hold), .stall_fire(stall_fire),
    .ovr_on(ovr_on), .ovr_wr(ovr_wr), .stall_pulse(stall_pulse),
    .link_ok(link_ok), .link_fail(link_fail)
  );

  lrw_satcnt #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(stall_fire), .value(stall_count)
  );

  lrw_merge #(
    .WORD_W(WORD_W), .DATA_EN_BIT(DATA_EN_BIT), .PLL_EN_BIT(PLL_EN_BIT)
  ) u_merge (
    .rd_word(ovr_rd_word), .force_on(ovr_on), .wr_word(ovr_wr_word)
  );

  assert_fire_needs_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fire |-> (!rx_valid && !link_up));
  assert_fire_needs_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fire |-> (ltssm_state == STATE_W'(STALL_STATE)));
  assert_fire_then_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fire |=> stall_pulse);
endmodule

// File: tb/test_link_stall_watchdog.sv
module test_link_stall_watchdog;
  localparam int GAP = 8;
  localparam int HOLD = 12;
  localparam int MAXC = 6;
  localparam int CW = 2;
  localparam int CMAX = 3;
  localparam logic [15:0] OWN = 16'h0028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ltssm_state = 6'h00;
  logic link_up = 1'b0;
  logic rx_valid = 1'b0;
  logic [15:0] ovr_rd_word = 16'h0000;
  logic [15:0] ovr_wr_word;
  logic ovr_wr, stall_pulse, link_ok, link_fail;
  logic [CW-1:0] stall_count;

  always #4 clk = ~clk;

  link_stall_watchdog #(
    .GAP_CYCLES(GAP), .HOLD_CYCLES(HOLD), .MAX_CHECKS(MAXC), .CNT_W(CW)
  ) i_link_stall_watchdog (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state), .link_up(link_up),
    .rx_valid(rx_valid), .ovr_rd_word(ovr_rd_word), .ovr_wr_word(ovr_wr_word),
    .ovr_wr(ovr_wr), .stall_pulse(stall_pulse), .stall_count(stall_count),
    .link_ok(link_ok), .link_fail(link_fail)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference model
  int m_phase, m_gap, m_tries, m_hold, m_cnt;
  bit m_ok, m_fail, m_pulse, m_on, m_wr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_gap = 0; m_tries = 0; m_hold = 0; m_cnt = 0;
      m_ok = 0; m_fail = 0; m_pulse = 0; m_on = 0; m_wr = 0;
    end else begin
      cyc++;
      m_pulse = 0; m_wr = 0;
      if (m_phase == 0) begin
        if (m_gap == GAP - 1) begin
          m_gap = 0;
          if (link_up) begin m_ok = 1; m_phase = 2; end
          else if (m_tries == MAXC - 1) begin m_fail = 1; m_phase = 2; end
          else begin
            m_tries++;
            if (ltssm_state == 6'h0D && !rx_valid) begin
              m_phase = 1; m_hold = 0; m_on = 1; m_wr = 1; m_pulse = 1;
              if (m_cnt < CMAX) m_cnt++;
            end
          end
        end else m_gap++;
      end else if (m_phase == 1) begin
        if (m_hold == HOLD - 1) begin m_on = 0; m_wr = 1; m_phase = 0; m_gap = 0; end
        else m_hold++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  int last_pulse = -1;

  task automatic step(input logic [5:0] st, input logic lu, input logic rv);
    @(negedge clk);
    chk("R2 link_ok", int'(link_ok), int'(m_ok));
    chk("R9 link_fail", int'(link_fail), int'(m_fail));
    chk("R3 stall_pulse", int'(stall_pulse), int'(m_pulse));
    chk("R10 stall_count", int'(stall_count), m_cnt);
    chk("R7 ovr_wr", int'(ovr_wr), int'(m_wr));
    chk("R6 ovr_wr_word", int'(ovr_wr_word), int'((ovr_rd_word & ~OWN) | (m_on ? OWN : 16'h0)));
    if (stall_pulse) begin
      if (last_pulse >= 0) chk("R8 pulse spacing", cyc - last_pulse, HOLD + GAP);
      last_pulse = cyc;
    end
    ltssm_state = st; link_up = lu; rx_valid = rv;
    ovr_rd_word = 16'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    last_pulse = -1;
    @(negedge clk);
    // R1: reset values
    chk("R1 reset ok", int'(link_ok), 0);
    chk("R1 reset fail", int'(link_fail), 0);
    chk("R1 reset count", int'(stall_count), 0);
    chk("R1 reset strobe", int'(ovr_wr), 0);
    chk("R1 reset word", int'(ovr_wr_word), int'(ovr_rd_word & ~OWN));
    rst_n = 1'b1;
  endtask

  initial begin
    // scenario A: persistent stall, counter saturation, failure verdict
    do_reset();
    for (int i = 0; i < 160; i++) step(6'h0D, 1'b0, 1'b0);
    chk("R10 saturated", int'(stall_count), CMAX);
    chk("R9 failed", int'(link_fail), 1);
    // scenario B: receive-valid present
    do_reset();
    for (int i = 0; i < 80; i++) step(6'h0D, 1'b0, 1'b1);
    chk("R4 no stall counted", int'(stall_count), 0);
    chk("R4 bits clear", int'(ovr_wr_word & OWN), 0);
    // scenario C: other LTSSM state
    do_reset();
    for (int i = 0; i < 80; i++) step(6'h11, 1'b0, 1'b0);
    chk("R5 no stall counted", int'(stall_count), 0);
    chk("R5 bits clear", int'(ovr_wr_word & OWN), 0);
    // scenario D: one stall, then link comes up
    do_reset();
    for (int i = 0; i < 12; i++) step(6'h0D, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) step(6'h0D, 1'b1, 1'b0);
    chk("R2 link up", int'(link_ok), 1);
    chk("R2 one stall only", int'(stall_count), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule